// File: doc/BRIEF.md
# Bus-Activity Watchdog and Reset Generator

This block drives the system reset line of a processor subsystem. From the moment the chip reset is applied, and again whenever the supply-good flag drops, it holds the reset output active. It releases the output only after the flag has stayed high for a fixed number of millisecond ticks. The comparison of the analog supply against its threshold happens elsewhere; this block sees only the resulting digital flag.

While the system runs, the block watches the clock and data wires of a two-wire serial bus. A bus start condition followed by a bus stop condition counts as a sign of life and restarts a watchdog counter. The watchdog period is chosen by a 2-bit code, and one code value turns the watchdog off. If the counter runs out before a restart arrives, the block asserts reset for a fixed number of ticks and then starts a new watch period.

All timing is counted in pulses of a prescaled tick input, nominally one per millisecond. Every period is a parameter, so a simulation can use short periods. The active level of the reset output is also a parameter.

Top module: `bwd_reset_gen`

## Requirements
- R1: While `rst` is high, the reset output is driven to its active level from the next clock edge.
- R2: When `supply_ok` goes low, the reset output is at its active level no later than the third clock edge after the change.
- R3: The reset output leaves its active level only after `supply_ok` has been high without a break for HOLD_TICKS ticks. Any drop during that time starts the count again from zero.
- R4: The period code `wd_sel` selects the watchdog period: 2'b00 gives T_LONG ticks, 2'b01 gives T_MID ticks, 2'b10 gives T_SHORT ticks, and 2'b11 turns the watchdog off so that it never expires.
- R5: If no restart arrives within the selected number of ticks while reset is inactive, the reset output goes active.
- R6: A watchdog timeout holds reset active for PULSE_TICKS ticks, after which the output releases with no other action needed.
- R7: A start condition (data falling while the bus clock is high) followed by a stop condition (data rising while the bus clock is high) clears the watchdog count.
- R8: A start condition that no stop condition follows does not clear the watchdog count.
- R9: The watchdog count is held at zero while reset is active, so each release begins a full period.
- R10: With RST_ACTIVE_HIGH = 1 the active level is 1. With RST_ACTIVE_HIGH = 0 the active level is 0.
- R11: Data transitions made while the bus clock is low are ignored and neither restart the watchdog nor start a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high chip reset |
| ms_tick | input | 1 | One-cycle time-base strobe, nominally once per millisecond |
| supply_ok | input | 1 | Supply-good flag from the external comparator, asynchronous |
| bus_scl | input | 1 | Serial bus clock wire, asynchronous |
| bus_sda | input | 1 | Serial bus data wire, asynchronous |
| wd_sel | input | 2 | Watchdog period code (00 long, 01 mid, 10 short, 11 off) |
| sys_rst_out | output | 1 | Registered system reset, level set by RST_ACTIVE_HIGH |

## Verification
The properties assume that `ms_tick` is a single-cycle pulse spaced several clocks apart. They also assume that each level on the bus wires is held for at least three clocks, so the synchronizers never miss an edge and never see the clock wire and the data wire change in the same sampled cycle. The stimulus meets these assumptions by keeping every bus level for three clocks and by placing ticks twenty clocks apart. Each start and stop sequence finishes within one tick interval, so its effect on the count is the same wherever it falls between two ticks.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_OFF   = 2'b11
  } wd_sel_e;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'b00,
    ST_RUN   = 2'b01,
    ST_PULSE = 2'b10
  } rg_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bwd_sync.sv
module bwd_sync #(
  parameter int            W      = 3,
  parameter int            STAGES = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign d_sync[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/bwd_bus_cond.sv
module bwd_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_p,
  output logic stop_p
);

  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // Both samples must see the clock wire high for the data edge to count.
  assign start_p = scl_q & scl_s &  sda_q & ~sda_s;
  assign stop_p  = scl_q & scl_s & ~sda_q &  sda_s;

endmodule

// File: rtl/bwd_wd_timer.sv
module bwd_wd_timer
  import bwd_pkg::*;
#(
  parameter int T_LONG  = 1400,
  parameter int T_MID   = 600,
  parameter int T_SHORT = 200,
  parameter int CNT_W   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             tick,
  input  logic             start_p,
  input  logic             stop_p,
  input  logic [1:0]       sel,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] last_val;
  logic             enabled;
  logic             pending;
  logic             kick;
  logic             at_end;

  always_comb begin
    enabled  = 1'b1;
    last_val = '0;
    unique case (wd_sel_e'(sel))
      SEL_LONG:  last_val = CNT_W'(T_LONG - 1);
      SEL_MID:   last_val = CNT_W'(T_MID - 1);
      SEL_SHORT: last_val = CNT_W'(T_SHORT - 1);
      default:   enabled  = 1'b0;
    endcase
  end

  assign kick   = stop_p & pending;
  assign at_end = cnt >= last_val;

  always_ff @(posedge clk) begin
    if (rst || hold) pending <= 1'b0;
    else if (start_p) pending <= 1'b1;
    else if (stop_p)  pending <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || hold || kick || !enabled) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else if (tick) begin
      cnt    <= at_end ? '0 : cnt + 1'b1;
      expire <= at_end;
    end else begin
      expire <= 1'b0;
    end
  end

endmodule

// File: rtl/bwd_rst_ctrl.sv
module bwd_rst_ctrl
  import bwd_pkg::*;
#(
  parameter int HOLD_TICKS  = 200,
  parameter int PULSE_TICKS = 200,
  parameter int CNT_W       = 11,
  parameter bit ACT_HIGH    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic supply_s,
  input  logic wd_expire,
  output logic in_reset,
  output logic rst_out
);

  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_TICKS - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_TICKS - 1);

  rg_state_e        st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    unique case (st)
      ST_HOLD: begin
        if (!supply_s) cnt_n = '0;
        else if (tick) begin
          if (cnt >= HOLD_LAST) begin
            st_n  = ST_RUN;
            cnt_n = '0;
          end else cnt_n = cnt + 1'b1;
        end
      end
      ST_RUN: begin
        if (!supply_s) begin
          st_n  = ST_HOLD;
          cnt_n = '0;
        end else if (wd_expire) begin
          st_n  = ST_PULSE;
          cnt_n = '0;
        end
      end
      ST_PULSE: begin
        if (!supply_s) begin
          st_n  = ST_HOLD;
          cnt_n = '0;
        end else if (tick) begin
          if (cnt >= PULSE_LAST) begin
            st_n  = ST_RUN;
            cnt_n = '0;
          end else cnt_n = cnt + 1'b1;
        end
      end
      default: begin
        st_n  = ST_HOLD;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_HOLD;
      cnt     <= '0;
      rst_out <= ACT_HIGH;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      rst_out <= (st_n != ST_RUN) ? ACT_HIGH : ~ACT_HIGH;
    end
  end

  assign in_reset = (st != ST_RUN);

endmodule

// File: rtl/bwd_reset_gen.sv
module bwd_reset_gen
  import bwd_pkg::*;
#(
  parameter int T_LONG          = 1400,
  parameter int T_MID           = 600,
  parameter int T_SHORT         = 200,
  parameter int HOLD_TICKS      = 200,
  parameter int PULSE_TICKS     = 200,
  parameter int SYNC_STAGES     = 2,
  parameter bit RST_ACTIVE_HIGH = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       supply_ok,
  input  logic       bus_scl,
  input  logic       bus_sda,
  input  logic [1:0] wd_sel,
  output logic       sys_rst_out
);

  localparam int MAX_T = max_of(max_of(T_LONG, T_MID),
                                max_of(T_SHORT, max_of(HOLD_TICKS, PULSE_TICKS)));
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic [2:0]       raw_in, syn_in;
  logic             scl_s, sda_s, sup_s;
  logic             start_p, stop_p;
  logic             wd_expire;
  logic [CNT_W-1:0] wd_cnt;
  logic             in_reset;

  assign raw_in = {supply_ok, bus_sda, bus_scl};
  assign scl_s  = syn_in[0];
  assign sda_s  = syn_in[1];
  assign sup_s  = syn_in[2];

  bwd_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)
  ) u_sync (
    .clk(clk), .rst(rst), .d_async(raw_in), .d_sync(syn_in)
  );

  bwd_bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .start_p(start_p), .stop_p(stop_p)
  );

  bwd_wd_timer #(
    .T_LONG(T_LONG), .T_MID(T_MID), .T_SHORT(T_SHORT), .CNT_W(CNT_W)
  ) u_wd (
    .clk(clk), .rst(rst), .hold(in_reset), .tick(ms_tick),
    .start_p(start_p), .stop_p(stop_p), .sel(wd_sel),
    .expire(wd_expire), .cnt(wd_cnt)
  );

  bwd_rst_ctrl #(
    .HOLD_TICKS(HOLD_TICKS), .PULSE_TICKS(PULSE_TICKS),
    .CNT_W(CNT_W), .ACT_HIGH(RST_ACTIVE_HIGH)
  ) u_ctrl (
    .clk(clk), .rst(rst), .tick(ms_tick), .supply_s(sup_s),
    .wd_expire(wd_expire), .in_reset(in_reset), .rst_out(sys_rst_out)
  );

endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
  parameter int CNT_W    = 11,
  parameter bit ACT_HIGH = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             sup_s,
  input logic             in_reset,
  input logic             wd_expire,
  input logic [CNT_W-1:0] wd_cnt,
  input logic             rst_out
);

  // R1: chip reset forces the active level on the following edge
  p_reset_forces_r1: assert property (@(posedge clk)
    rst |=> (rst_out == ACT_HIGH));

  // R2: a low supply sample puts the controller in reset next cycle
  p_supply_low_r2: assert property (@(posedge clk) disable iff (rst)
    !sup_s |=> in_reset);

  // R3: leaving reset needs supply good in the cycle before
  p_release_needs_supply_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(in_reset) |-> $past(sup_s));

  // R5: an expiry with good supply drives the output active
  p_expire_asserts_r5: assert property (@(posedge clk) disable iff (rst)
    (wd_expire && sup_s) |=> (rst_out == ACT_HIGH));

  // R9: the watchdog count is zero during reset
  p_count_held_r9: assert property (@(posedge clk) disable iff (rst)
    in_reset |=> (wd_cnt == '0));

  // R10: output level agrees with the controller's reset state
  p_level_r10: assert property (@(posedge clk) disable iff (rst)
    (rst_out == ACT_HIGH) == in_reset);

endmodule

bind bwd_reset_gen bwd_checker #(
  .CNT_W(CNT_W), .ACT_HIGH(RST_ACTIVE_HIGH)
) u_chk (
  .clk(clk), .rst(rst), .sup_s(sup_s), .in_reset(in_reset),
  .wd_expire(wd_expire), .wd_cnt(wd_cnt), .rst_out(sys_rst_out)
);

// File: tb/sim_bwd_reset_gen.sv
module sim_bwd_reset_gen;

  localparam int TL = 12, TM = 6, TS = 3, HOLD = 5, PULSE = 4;
  localparam int TICK_DIV = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       supply_ok = 1'b0;
  logic       scl = 1'b1, sda = 1'b1;
  logic [1:0] sel = 2'b11;
  logic       out_h, out_l;
  int         n_chk = 0, n_err = 0;
  int         div = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    div  <= (div == TICK_DIV - 1) ? 0 : div + 1;
    tick <= (div == TICK_DIV - 1);
  end

  bwd_reset_gen #(
    .T_LONG(TL), .T_MID(TM), .T_SHORT(TS), .HOLD_TICKS(HOLD),
    .PULSE_TICKS(PULSE), .RST_ACTIVE_HIGH(1'b1)
  ) u0 (
    .clk(clk), .rst(rst), .ms_tick(tick), .supply_ok(supply_ok),
    .bus_scl(scl), .bus_sda(sda), .wd_sel(sel), .sys_rst_out(out_h)
  );

  bwd_reset_gen #(
    .T_LONG(TL), .T_MID(TM), .T_SHORT(TS), .HOLD_TICKS(HOLD),
    .PULSE_TICKS(PULSE), .RST_ACTIVE_HIGH(1'b0)
  ) u1 (
    .clk(clk), .rst(rst), .ms_tick(tick), .supply_ok(supply_ok),
    .bus_scl(scl), .bus_sda(sda), .wd_sel(sel), .sys_rst_out(out_l)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (tick) k++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_step(input logic c, input logic d);
    scl = c;
    sda = d;
    repeat (3) @(negedge clk);
  endtask

  task automatic kick();
    bus_step(1'b1, 1'b1);
    bus_step(1'b1, 1'b0);
    bus_step(1'b0, 1'b0);
    bus_step(1'b1, 1'b0);
    bus_step(1'b1, 1'b1);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    check("R1 reset state", out_h, 1'b1);
    check("R10 low-active level in reset", out_l, 1'b0);
  endtask

  task automatic t_powerup();
    rst = 1'b0;
    supply_ok = 1'b1;
    wait_ticks(HOLD - 1);
    check("R3 held before hold time", out_h, 1'b1);
    wait_ticks(3);
    check("R3 released after hold time", out_h, 1'b0);
    check("R10 low-active released level", out_l, 1'b1);
  endtask

  task automatic t_brownout();
    supply_ok = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 supply drop asserts", out_h, 1'b1);
    supply_ok = 1'b1;
    wait_ticks(2);
    supply_ok = 1'b0;
    repeat (2) @(negedge clk);
    supply_ok = 1'b1;
    wait_ticks(HOLD - 1);
    check("R3 hold count restarts after glitch", out_h, 1'b1);
    wait_ticks(3);
    check("R3 release after glitch", out_h, 1'b0);
  endtask

  task automatic t_disabled();
    sel = 2'b11;
    wait_ticks(TL + 8);
    check("R4 code 11 never expires", out_h, 1'b0);
  endtask

  task automatic t_timeout();
    sel = 2'b10;
    wait_ticks(TS - 1);
    check("R5 no timeout before period", out_h, 1'b0);
    wait_ticks(1);
    check("R5 timeout asserts", out_h, 1'b1);
    wait_ticks(PULSE - 1);
    check("R6 pulse still active", out_h, 1'b1);
    wait_ticks(2);
    check("R6 pulse released", out_h, 1'b0);
    wait_ticks(1);
    check("R9 full period after release", out_h, 1'b0);
    wait_ticks(1);
    check("R9 expiry one period after release", out_h, 1'b1);
    sel = 2'b11;
    wait_ticks(PULSE + 1);
    check("R6 release before code test", out_h, 0);
  endtask

  task automatic t_code(input logic [1:0] code, input int per, input string tag);
    sel = code;
    wait_ticks(per - 1);
    check({tag, " before period"}, out_h, 1'b0);
    wait_ticks(1);
    check({tag, " at period"}, out_h, 1'b1);
    sel = 2'b11;
    wait_ticks(PULSE + 1);
  endtask

  task automatic t_kick();
    sel = 2'b10;
    for (int i = 0; i < 8; i++) begin
      kick();
      wait_ticks(1);
      check("R7 start-stop keeps running", out_h, 1'b0);
    end
  endtask

  task automatic t_start_only();
    kick();
    wait_ticks(1);
    bus_step(1'b1, 1'b0);
    bus_step(1'b0, 1'b0);
    wait_ticks(1);
    check("R8 start alone, before period", out_h, 1'b0);
    wait_ticks(1);
    check("R8 start alone does not restart", out_h, 1'b1);
    bus_step(1'b1, 1'b0);
    bus_step(1'b1, 1'b1);
    sel = 2'b11;
    wait_ticks(PULSE + 1);
    check("R8 recovery after pulse", out_h, 1'b0);
  endtask

  task automatic t_low_clock_data();
    sel = 2'b10;
    kick();
    wait_ticks(1);
    for (int i = 0; i < 10; i++) begin
      bus_step(1'b0, ~sda);
      bus_step(1'b1, sda);
    end
    check("R11 data edges with clock low ignored", out_h, 1'b1);
    bus_step(1'b0, 1'b1);
    bus_step(1'b1, 1'b1);
    sel = 2'b11;
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_brownout();
    t_disabled();
    t_timeout();
    t_code(2'b00, TL, "R4 code 00 long");
    t_code(2'b01, TM, "R4 code 01 mid");
    t_kick();
    t_start_only();
    t_low_clock_data();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

endmodule